// File: doc/BRIEF.md
# Bit-Masked Word Writer

This block lets a memory update only chosen bits of a word and leave the rest as they were. At the start of each row cycle, when the active-low row strobe falls, it takes the word on the shared data bus as a bit mask. The mask then stays fixed for every write in that row cycle, including each write of a page-mode burst. Later activity on the bus during the row cycle is treated as write data only.

Each write is a read-modify-write against an external word store. The store presents the current contents of the addressed word. The block returns the merged word and a one-cycle write strobe. In the merged word, bits whose mask bit is one take the bus data, and bits whose mask bit is zero keep the stored value. Address timing and the storage array sit outside the block.

A parameter can remove the masking. In that case every write replaces the whole word.

Top module: `wpb_mask_unit`

## Requirements
- R1: The mask register loads the bus value on the first clock at which the row strobe `row_n_i` is sampled low after being sampled high on the previous clock.
- R2: A write that is accepted at clock k drives `st_we_o` high after clock k and drives `st_wdata_o` = (old AND NOT mask) OR (data AND mask). Here old is `old_word_i` at clock k, data is `bus_i` at clock k, and mask is the mask that was held at clock k.
- R3: While the row strobe stays low, changes on `bus_i` do not alter the mask. Every write of a burst in one row cycle uses the mask captured at that row cycle's falling edge.
- R4: A write is accepted only at a clock where `row_n_i`, `col_n_i` and `we_n_i` are all low. At any other clock, `st_we_o` is low after that clock.
- R5: At the clock that captures a mask, no write is accepted, even when the column strobe and write enable are low.
- R6: Reset is asynchronous and active low. It clears `st_we_o` and `st_wdata_o` to zero and sets the mask to all ones. If the row strobe is already low when reset is released, no capture takes place, and writes use the all-ones mask.
- R7: With `MASK_EN` = 0, the mask is all ones at all times, so an accepted write drives `st_wdata_o` = `bus_i` of the request clock.
- R8: Each new row cycle captures a new mask, which replaces the mask of the previous row cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n_i | input | 1 | Row strobe, active low; its falling edge captures the mask |
| col_n_i | input | 1 | Column strobe qualifier, active low |
| we_n_i | input | 1 | Write enable qualifier, active low |
| bus_i | input | DATA_W | Shared data bus: mask at the row edge, write data afterwards |
| old_word_i | input | DATA_W | Current contents of the addressed word from the store |
| st_we_o | output | 1 | Write strobe to the store, one cycle after the request |
| st_wdata_o | output | DATA_W | Merged word to write into the store |

## Verification
The assertions assume that the store presents `old_word_i` for the addressed word during the same clock as the write request. They also assume that the strobes are synchronous to `clk`, so that a fall of `row_n_i` between two samples marks a row-cycle start. The stimulus changes every input only at the falling clock edge. It keeps the old word and the data steady for the whole request clock, and it opens each row cycle with a high-then-low strobe. The one exception is the reset test, which holds the strobe low across reset on purpose.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

   // Sampled state of the three active-low strobes for one clock.
   typedef struct packed {
      logic row_n;
      logic col_n;
      logic we_n;
   } wpb_strobe_t;

   // Decode of one clock's strobe state once the row edge is known.
   typedef enum logic [1:0] {
      WPB_IDLE    = 2'd0,
      WPB_CAPTURE = 2'd1,
      WPB_WRITE   = 2'd2
   } wpb_op_e;

   function automatic wpb_op_e wpb_decode(input wpb_strobe_t s, input logic row_fall);
      wpb_op_e op;
      op = WPB_IDLE;
      if (row_fall)
         op = WPB_CAPTURE;
      else if (!s.row_n && !s.col_n && !s.we_n)
         op = WPB_WRITE;
      return op;
   endfunction

endpackage

// File: rtl/wpb_row_edge.sv
module wpb_row_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic row_n_i,
   output logic fall_o
);

   logic prev_q;

   // While reset is held the previous-sample register tracks the strobe, so
   // a strobe held low across reset release gives no edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= row_n_i;
      else
         prev_q <= row_n_i;
   end

   assign fall_o = prev_q & ~row_n_i;

endmodule

// File: rtl/wpb_mask_latch.sv
module wpb_mask_latch #(
   parameter int DATA_W  = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] mask_o
);

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   generate
      if (MASK_EN) begin : g_masked
         logic [DATA_W-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_q <= ALL_ONES;
            else if (cap_i)
               mask_q <= d_i;
         end
         assign mask_o = mask_q;
      end else begin : g_full
         logic unused_sink;
         assign unused_sink = ^{clk, rst_n, cap_i, d_i};
         assign mask_o = ALL_ONES;
      end
   endgenerate

endmodule

// File: rtl/wpb_bit_merge.sv
module wpb_bit_merge #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic [DATA_W-1:0] word_o
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign word_o[b] = mask_i[b] ? data_i[b] : old_i[b];
   end

endmodule

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit
   import wpb_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_n_i,
   input  logic              col_n_i,
   input  logic              we_n_i,
   input  logic [DATA_W-1:0] bus_i,
   input  logic [DATA_W-1:0] old_word_i,
   output logic              st_we_o,
   output logic [DATA_W-1:0] st_wdata_o
);

   localparam logic [DATA_W-1:0] ZERO_WORD = '0;

   if (DATA_W < 1) begin : g_bad_width
      $error("wpb_mask_unit: DATA_W must be at least 1");
   end

   logic              row_fall;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] merged;
   wpb_strobe_t       strobes;
   wpb_op_e           op;

   assign strobes = '{row_n: row_n_i, col_n: col_n_i, we_n: we_n_i};

   wpb_row_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_n_i (row_n_i),
      .fall_o  (row_fall)
   );

   assign op = wpb_decode(strobes, row_fall);

   wpb_mask_latch #(.DATA_W(DATA_W), .MASK_EN(MASK_EN)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (op == WPB_CAPTURE),
      .d_i    (bus_i),
      .mask_o (mask_q)
   );

   wpb_bit_merge #(.DATA_W(DATA_W)) u_merge (
      .old_i  (old_word_i),
      .data_i (bus_i),
      .mask_i (mask_q),
      .word_o (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_we_o    <= 1'b0;
         st_wdata_o <= ZERO_WORD;
      end else begin
         st_we_o <= (op == WPB_WRITE);
         if (op == WPB_WRITE)
            st_wdata_o <= merged;
      end
   end

endmodule

// File: rtl/wpb_mask_unit_chk.sv
module wpb_mask_unit_chk #(
   parameter int DATA_W  = 8,
   parameter bit MASK_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              row_n_i,
   input logic              col_n_i,
   input logic              we_n_i,
   input logic [DATA_W-1:0] bus_i,
   input logic [DATA_W-1:0] old_word_i,
   input logic              st_we_o,
   input logic [DATA_W-1:0] st_wdata_o,
   input logic [DATA_W-1:0] mask_q
);

   // R4: a strobe needs all three qualifiers low on the previous clock
   a_r4_write_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      st_we_o |-> $past(!row_n_i && !col_n_i && !we_n_i));

   // R5: the capturing clock never issues a write
   a_r5_capture_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(row_n_i) |=> !st_we_o);

   // R2: unmasked bits keep the old word
   a_r2_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      st_we_o |-> (((st_wdata_o ^ $past(old_word_i)) & ~$past(mask_q)) == '0));

   // R2: masked bits take the bus data
   a_r2_take_masked: assert property (@(posedge clk) disable iff (!rst_n)
      st_we_o |-> (((st_wdata_o ^ $past(bus_i)) & $past(mask_q)) == '0));

   // R3: no row edge, no mask change
   a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(row_n_i) |=> $stable(mask_q));

   if (MASK_EN) begin : g_en
      // R1: a row edge loads the bus into the mask
      a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(row_n_i) |=> (mask_q == $past(bus_i)));
   end else begin : g_dis
      // R7: with masking removed the whole word is replaced
      a_r7_full_write: assert property (@(posedge clk) disable iff (!rst_n)
         st_we_o |-> (st_wdata_o == $past(bus_i)));
   end

endmodule

bind wpb_mask_unit wpb_mask_unit_chk #(.DATA_W(DATA_W), .MASK_EN(MASK_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .row_n_i    (row_n_i),
   .col_n_i    (col_n_i),
   .we_n_i     (we_n_i),
   .bus_i      (bus_i),
   .old_word_i (old_word_i),
   .st_we_o    (st_we_o),
   .st_wdata_o (st_wdata_o),
   .mask_q     (mask_q)
);

// File: tb/wpb_mask_unit_bench.sv
module wpb_mask_unit_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         row_n = 1'b1;
   logic         col_n = 1'b1;
   logic         we_n = 1'b1;
   logic [W-1:0] bus = '0;
   logic [W-1:0] old = '0;
   logic         we_m, we_f;
   logic [W-1:0] wd_m, wd_f;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   wpb_mask_unit #(.DATA_W(W), .MASK_EN(1'b1)) u_wpb_mask_unit (
      .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .col_n_i(col_n), .we_n_i(we_n),
      .bus_i(bus), .old_word_i(old), .st_we_o(we_m), .st_wdata_o(wd_m));

   wpb_mask_unit #(.DATA_W(W), .MASK_EN(1'b0)) u_wpb_mask_unit_full (
      .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .col_n_i(col_n), .we_n_i(we_n),
      .bus_i(bus), .old_word_i(old), .st_we_o(we_f), .st_wdata_o(wd_f));

   task automatic step(input logic r, input logic c, input logic w,
                       input logic [W-1:0] b, input logic [W-1:0] o);
      row_n = r; col_n = c; we_n = w; bus = b; old = o;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp_we,
                        input logic [W-1:0] exp_m, input logic [W-1:0] exp_f);
      checks++;
      if (we_m !== exp_we || (exp_we && wd_m !== exp_m)) begin
         failures++;
         $display("FAIL %s masked: we=%b data=%h expected we=%b data=%h",
                  req, we_m, wd_m, exp_we, exp_m);
      end
      checks++;
      if (we_f !== exp_we || (exp_we && wd_f !== exp_f)) begin
         failures++;
         $display("FAIL %s R7 full: we=%b data=%h expected we=%b data=%h",
                  req, we_f, wd_f, exp_we, exp_f);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [W-1:0] d, o, e;
      repeat (3) @(negedge clk);
      // R6: outputs are zero while reset is held
      checks++;
      if (we_m !== 1'b0 || wd_m !== '0 || we_f !== 1'b0 || wd_f !== '0) begin
         failures++;
         $display("FAIL R6 reset: we=%b data=%h expected we=0 data=00", we_m, wd_m);
      end
      rst_n = 1'b1;
      step(1, 1, 1, 8'h00, 8'h00);
      check("R6 idle", 1'b0, '0, '0);

      // R4: write qualifiers with the row strobe high are ignored
      step(1, 0, 0, 8'hC3, 8'h11);
      check("R4 row high", 1'b0, '0, '0);

      // R5: the capture clock with column and write enable low is not a write
      step(0, 0, 0, 8'h0F, 8'h55);
      check("R5 capture", 1'b0, '0, '0);
      step(0, 0, 0, 8'hAA, 8'h55);
      check("R1 R2 first write", 1'b1, 8'h5A, 8'hAA);
      step(1, 1, 1, 8'h00, 8'h00);

      // R1 R2 R3 R8: sweep every mask, burst of four writes per row cycle
      for (int m = 0; m < 256; m++) begin
         step(1, 1, 1, 8'hFF, 8'h00);
         check("R4 precharge", 1'b0, '0, '0);
         step(0, 1, 1, W'(m), 8'h00);
         check("R1 capture", 1'b0, '0, '0);
         for (int j = 0; j < 4; j++) begin
            d = W'(m * 7 + j * 37 + 3);
            o = W'(~m) ^ W'(j * 90);
            e = (o & ~W'(m)) | (d & W'(m));
            step(0, 0, 0, d, o);
            check("R2 R3 R8 burst write", 1'b1, e, d);
         end
         step(0, 1, 0, W'(m + 1), 8'h3C);
         check("R4 column high", 1'b0, '0, '0);
         step(0, 0, 1, W'(m + 2), 8'h3C);
         check("R4 write enable high", 1'b0, '0, '0);
      end

      // R6: strobe held low across reset release -> no capture, all-ones mask
      step(0, 1, 1, 8'h00, 8'h00);
      rst_n = 1'b0;
      step(0, 1, 1, 8'h00, 8'h00);
      rst_n = 1'b1;
      step(0, 0, 0, 8'h96, 8'h69);
      check("R6 reset mask", 1'b1, 8'h96, 8'h96);
      step(1, 1, 1, 8'h00, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule